// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block keeps a short, rolling record of serviced interrupts for debug and profiling. Each interrupt line has a request input. When a request newly goes high, the block latches the free-running cycle count into a raise-time register for that line. A service event (a take) writes one history entry into a circular store. The entry holds the serviced line number, the raise cycle latched for that line and the current cycle, which is the take time. A new take overwrites the oldest entry once the store is full.

A combinational readout port turns a history index into one entry. Index 0 is the most recent take and higher indices go back in time. For each entry the port gives the latency from raise to take, and the gap in cycles to the next newer entry. Readout stops at the first empty slot: that slot and every older index are reported invalid. A separate counter totals every rising request edge across all lines.

Inputs are level requests and a one-cycle take pulse. Both are accepted in every cycle and there is no back-pressure. The readout index can change in any cycle, and the outputs follow it within the same cycle.

Top module: `latency_hist`

## Requirements
- R1: When bit L of `raise_req` is high and was low in the previous cycle (or is the first high value after reset), line L's raise-time register takes the value of `cycle`. A request that stays high does not overwrite it.
- R2: If line L's request rises in the same cycle that line L is taken, the entry records the current `cycle` as its raise time, which gives a latency of 0.
- R3: A cycle with `take_valid` high writes `take_line`, the line's raise time and `cycle` (as the take time) into the slot at the write index. That entry appears at readout index 0 from the next cycle onward.
- R4: The write index starts at 0 and advances by one per take. It wraps to 0 after DEPTH-1, so the oldest entry is overwritten. DEPTH is a power of two.
- R5: Readout index k shows the slot at (write index − k − 1) mod DEPTH.
- R6: A slot with a take time of 0 is empty. `rd_valid` is high only if the addressed slot and every newer slot in readout order are non-empty. While `rd_valid` is low, all data outputs read 0.
- R7: `rd_latency` equals the take time minus the raise time, modulo 2^CYC_W.
- R8: `rd_gap` equals the take time of the next newer entry (index k−1) minus this entry's take time, modulo 2^CYC_W. `rd_gap_valid` is high only when `rd_valid` is high and k is not 0.
- R9: `raise_count` grows each cycle by the number of lines whose request rises in that cycle, and wraps modulo 2^CNT_W.
- R10: An active-low `rst_n` clears all entries, the write index, the raise-time registers, the request history and `raise_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cycle | input | CYC_W | Free-running cycle count |
| raise_req | input | NUM_LINES | Per-line request levels |
| take_valid | input | 1 | One-cycle pulse: a line is being serviced |
| take_line | input | LINE_W | Number of the serviced line |
| rd_idx | input | IDX_W | History index, 0 = newest |
| rd_valid | output | 1 | Addressed entry holds valid history |
| rd_line | output | LINE_W | Line number of the entry |
| rd_raise_cyc | output | CYC_W | Raise cycle of the entry |
| rd_take_cyc | output | CYC_W | Take cycle of the entry |
| rd_latency | output | CYC_W | Take minus raise |
| rd_gap_valid | output | 1 | `rd_gap` is meaningful |
| rd_gap | output | CYC_W | Newer take minus this take |
| raise_count | output | CNT_W | Total rising request edges |

## Verification
A wrong raise-time register stays hidden until its line is next taken. After that take it shows at index 0 in the following cycle as a wrong raise time and a wrong latency. A wrong write index shows within one cycle of the next take: index 0 reads a stale entry, or the valid prefix ends at the wrong depth. A full walk of the readout indices after every step finds any error in addressing or gap arithmetic in the same cycle it appears. A wrong edge detector shows at once as a `raise_count` that is off by the missed or extra edges.

// File: rtl/lath_pkg.sv
package lath_pkg;
  localparam int unsigned LINES_DEF = 8;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned CYC_W_DEF = 16;
  localparam int unsigned CNT_W_DEF = 16;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/lath_stamp.sv
module lath_stamp #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned CYC_W     = 16,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CYC_W-1:0]     cycle,
  input  logic [NUM_LINES-1:0] raise_req,
  output logic [NUM_LINES-1:0] rise,
  output logic [CYC_W-1:0]     stamp [NUM_LINES],
  output logic [CNT_W-1:0]     raise_count
);
  localparam int unsigned ADD_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0] req_q;
  logic [ADD_W-1:0]     rise_n;

  // a rising edge is a high level that was low (or in reset) last cycle
  assign rise = raise_req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= raise_req;
  end

  always_comb begin
    rise_n = '0;
    for (int i = 0; i < NUM_LINES; i++) rise_n = rise_n + ADD_W'(rise[i]);
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)       stamp[l] <= '0;
      else if (rise[l]) stamp[l] <= cycle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raise_count <= '0;
    else        raise_count <= raise_count + CNT_W'(rise_n);
  end
endmodule

// File: rtl/lath_ring.sv
module lath_ring #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CYC_W  = 16,
  parameter int unsigned LINE_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cycle,
  input  logic              take_valid,
  input  logic [LINE_W-1:0] take_line,
  input  logic [CYC_W-1:0]  take_raise,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [LINE_W-1:0] mem_line  [DEPTH],
  output logic [CYC_W-1:0]  mem_raise [DEPTH],
  output logic [CYC_W-1:0]  mem_take  [DEPTH]
);
  // power-of-two depth: the index wraps by plain overflow
  always_ff @(posedge clk) begin
    if (!rst_n)          wr_idx <= '0;
    else if (take_valid) wr_idx <= wr_idx + IDX_W'(1);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit;
    assign hit = take_valid && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_line[e]  <= '0;
        mem_raise[e] <= '0;
        mem_take[e]  <= '0;
      end else if (hit) begin
        mem_line[e]  <= take_line;
        mem_raise[e] <= take_raise;
        mem_take[e]  <= cycle;
      end
    end
  end
endmodule

// File: rtl/lath_reader.sv
module lath_reader #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CYC_W  = 16,
  parameter int unsigned LINE_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [LINE_W-1:0] mem_line  [DEPTH],
  input  logic [CYC_W-1:0]  mem_raise [DEPTH],
  input  logic [CYC_W-1:0]  mem_take  [DEPTH],
  output logic              rd_valid,
  output logic [LINE_W-1:0] rd_line,
  output logic [CYC_W-1:0]  rd_raise_cyc,
  output logic [CYC_W-1:0]  rd_take_cyc,
  output logic [CYC_W-1:0]  rd_latency,
  output logic              rd_gap_valid,
  output logic [CYC_W-1:0]  rd_gap
);
  logic [DEPTH-1:0] live;

  // live[j]: readout positions 0..j all hold a non-zero take time
  for (genvar j = 0; j < DEPTH; j++) begin : g_walk
    logic [IDX_W-1:0] slot;
    assign slot = wr_idx - IDX_W'(j) - IDX_W'(1);
    if (j == 0) begin : g_first
      assign live[j] = |mem_take[slot];
    end else begin : g_rest
      assign live[j] = live[j-1] & (|mem_take[slot]);
    end
  end

  logic [IDX_W-1:0] newer;
  logic [IDX_W-1:0] cur;
  assign newer = wr_idx - rd_idx;
  assign cur   = newer - IDX_W'(1);

  always_comb begin
    rd_valid     = live[rd_idx];
    rd_line      = '0;
    rd_raise_cyc = '0;
    rd_take_cyc  = '0;
    rd_latency   = '0;
    rd_gap_valid = 1'b0;
    rd_gap       = '0;
    if (rd_valid) begin
      rd_line      = mem_line[cur];
      rd_raise_cyc = mem_raise[cur];
      rd_take_cyc  = mem_take[cur];
      rd_latency   = mem_take[cur] - mem_raise[cur];
      if (rd_idx != '0) begin
        rd_gap_valid = 1'b1;
        rd_gap       = mem_take[newer] - mem_take[cur];
      end
    end
  end
endmodule

// File: rtl/latency_hist.sv
module latency_hist #(
  parameter int unsigned NUM_LINES = lath_pkg::LINES_DEF,
  parameter int unsigned DEPTH     = lath_pkg::DEPTH_DEF,
  parameter int unsigned CYC_W     = lath_pkg::CYC_W_DEF,
  parameter int unsigned CNT_W     = lath_pkg::CNT_W_DEF,
  localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CYC_W-1:0]     cycle,
  input  logic [NUM_LINES-1:0] raise_req,
  input  logic                 take_valid,
  input  logic [LINE_W-1:0]    take_line,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_valid,
  output logic [LINE_W-1:0]    rd_line,
  output logic [CYC_W-1:0]     rd_raise_cyc,
  output logic [CYC_W-1:0]     rd_take_cyc,
  output logic [CYC_W-1:0]     rd_latency,
  output logic                 rd_gap_valid,
  output logic [CYC_W-1:0]     rd_gap,
  output logic [CNT_W-1:0]     raise_count
);
  if (!lath_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
    $error("latency_hist: DEPTH must be a power of two, at least 2");
  end

  logic [NUM_LINES-1:0] rise;
  logic [CYC_W-1:0]     stamp [NUM_LINES];
  logic [CYC_W-1:0]     take_raise;
  logic [IDX_W-1:0]     wr_idx;
  logic [LINE_W-1:0]    mem_line  [DEPTH];
  logic [CYC_W-1:0]     mem_raise [DEPTH];
  logic [CYC_W-1:0]     mem_take  [DEPTH];

  lath_stamp #(.NUM_LINES(NUM_LINES), .CYC_W(CYC_W), .CNT_W(CNT_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .cycle(cycle), .raise_req(raise_req),
    .rise(rise), .stamp(stamp), .raise_count(raise_count)
  );

  // bypass: a rise in the take cycle has not reached the stamp register yet
  always_comb begin
    take_raise = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (take_line == LINE_W'(l)) take_raise = rise[l] ? cycle : stamp[l];
    end
  end

  lath_ring #(.DEPTH(DEPTH), .CYC_W(CYC_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .cycle(cycle), .take_valid(take_valid),
    .take_line(take_line), .take_raise(take_raise), .wr_idx(wr_idx),
    .mem_line(mem_line), .mem_raise(mem_raise), .mem_take(mem_take)
  );

  lath_reader #(.DEPTH(DEPTH), .CYC_W(CYC_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_reader (
    .wr_idx(wr_idx), .rd_idx(rd_idx), .mem_line(mem_line), .mem_raise(mem_raise),
    .mem_take(mem_take), .rd_valid(rd_valid), .rd_line(rd_line),
    .rd_raise_cyc(rd_raise_cyc), .rd_take_cyc(rd_take_cyc), .rd_latency(rd_latency),
    .rd_gap_valid(rd_gap_valid), .rd_gap(rd_gap)
  );
endmodule

// File: rtl/lath_hist_chk.sv
module lath_hist_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned CYC_W     = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LINE_W    = 3,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CYC_W-1:0]     cycle,
  input logic [NUM_LINES-1:0] raise_req,
  input logic                 take_valid,
  input logic [LINE_W-1:0]    take_line,
  input logic [IDX_W-1:0]     rd_idx,
  input logic                 rd_valid,
  input logic [LINE_W-1:0]    rd_line,
  input logic [CYC_W-1:0]     rd_take_cyc,
  input logic [CNT_W-1:0]     raise_count,
  input logic [IDX_W-1:0]     wr_idx,
  input logic [CYC_W-1:0]     stamp [NUM_LINES]
);
  // R4
  wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |=> wr_idx == $past(wr_idx) + IDX_W'(1));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |=> $stable(wr_idx));

  // R3
  newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && cycle != '0) |=>
      (rd_idx != '0) || (rd_valid && rd_take_cyc == $past(cycle) && rd_line == $past(take_line)));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req == '0) |=> $stable(raise_count));

  // R6
  valid_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_take_cyc != '0);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_chk
    // R1
    stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_req[l] && !$past(raise_req[l])) |=> stamp[l] == $past(cycle));
  end
endmodule

bind latency_hist lath_hist_chk #(
  .NUM_LINES(NUM_LINES), .CYC_W(CYC_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle(cycle), .raise_req(raise_req),
  .take_valid(take_valid), .take_line(take_line), .rd_idx(rd_idx),
  .rd_valid(rd_valid), .rd_line(rd_line), .rd_take_cyc(rd_take_cyc),
  .raise_count(raise_count), .wr_idx(wr_idx), .stamp(stamp)
);

// File: tb/latency_hist_tb.sv
`timescale 1ns/100ps
module latency_hist_tb;
  localparam int NL = 4;
  localparam int D  = 4;
  localparam int CW = 12;
  localparam int NW = 6;
  localparam int LW = 2;
  localparam int IW = 2;
  localparam int CMASK = (1 << CW) - 1;
  localparam int NMASK = (1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cycle = '0;
  logic [NL-1:0] raise_req = '0;
  logic          take_valid = 1'b0;
  logic [LW-1:0] take_line = '0;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_valid, rd_gap_valid;
  logic [LW-1:0] rd_line;
  logic [CW-1:0] rd_raise_cyc, rd_take_cyc, rd_latency, rd_gap;
  logic [NW-1:0] raise_count;

  latency_hist #(.NUM_LINES(NL), .DEPTH(D), .CYC_W(CW), .CNT_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycle(cycle), .raise_req(raise_req),
    .take_valid(take_valid), .take_line(take_line), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_raise_cyc(rd_raise_cyc),
    .rd_take_cyc(rd_take_cyc), .rd_latency(rd_latency), .rd_gap_valid(rd_gap_valid),
    .rd_gap(rd_gap), .raise_count(raise_count)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cyc = 1;
  int m_stamp [NL];
  int m_line [D];
  int m_raise [D];
  int m_take [D];
  int m_wr;
  int m_cnt;
  bit [NL-1:0] m_prev;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NL; i++) m_stamp[i] = 0;
    for (int i = 0; i < D; i++) begin m_line[i] = 0; m_raise[i] = 0; m_take[i] = 0; end
    m_wr = 0; m_cnt = 0; m_prev = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raise_req = '0; take_valid = 1'b0; take_line = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  // drive one cycle of stimulus; model the clock edge it is taken on
  task automatic step(input bit [NL-1:0] req, input bit tv, input int tl);
    bit [NL-1:0] rise;
    @(negedge clk);
    raise_req = req; take_valid = tv; take_line = LW'(tl); cycle = CW'(cyc);
    @(posedge clk);
    rise = req & ~m_prev;
    if (tv) begin
      m_line[m_wr]  = tl;
      m_raise[m_wr] = rise[tl] ? cyc : m_stamp[tl];
      m_take[m_wr]  = cyc;
      m_wr = (m_wr + 1) % D;
    end
    for (int i = 0; i < NL; i++) if (rise[i]) m_stamp[i] = cyc;
    m_cnt = (m_cnt + $countones(rise)) & NMASK;
    m_prev = req;
    cyc = (cyc + 1) & CMASK;
  endtask

  task automatic peek(input int k);
    rd_idx = IW'(k);
    #0.5;
  endtask

  task automatic check_all();
    #0.5;
    for (int k = 0; k < D; k++) begin
      int a, nw;
      bit v;
      v = 1'b1;
      for (int j = 0; j <= k; j++) if (m_take[(m_wr - j - 1 + 2*D) % D] == 0) v = 1'b0;
      a  = (m_wr - k - 1 + 2*D) % D;
      nw = (a + 1) % D;
      peek(k);
      chk(rd_valid == v, "R6 valid prefix", rd_valid, v);
      if (v) begin
        chk(rd_line == LW'(m_line[a]), "R3 line", rd_line, m_line[a]);
        chk(rd_take_cyc == CW'(m_take[a]), "R5 take addr", rd_take_cyc, m_take[a]);
        chk(rd_raise_cyc == CW'(m_raise[a]), "R3 raise", rd_raise_cyc, m_raise[a]);
        chk(rd_latency == CW'((m_take[a] - m_raise[a]) & CMASK), "R7 latency",
            rd_latency, (m_take[a] - m_raise[a]) & CMASK);
      end else begin
        chk(rd_take_cyc == '0 && rd_line == '0 && rd_latency == '0, "R6 blanked", rd_take_cyc, 0);
      end
      chk(rd_gap_valid == (v && k > 0), "R8 gap valid", rd_gap_valid, (v && k > 0));
      if (v && k > 0)
        chk(rd_gap == CW'((m_take[nw] - m_take[a]) & CMASK), "R8 gap", rd_gap,
            (m_take[nw] - m_take[a]) & CMASK);
    end
    chk(raise_count == NW'(m_cnt), "R9 count", raise_count, m_cnt);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c1, tk2;
    bit [15:0] lf;
    model_clear();
    do_reset();
    // R10 reset state
    peek(0);
    chk(rd_valid == 1'b0, "R10 empty after reset", rd_valid, 0);
    chk(raise_count == '0, "R10 count after reset", raise_count, 0);
    check_all();

    // R1: held request keeps its first stamp
    c1 = cyc;
    step(4'b0010, 1'b0, 0); check_all();
    step(4'b0010, 1'b0, 0); check_all();
    step(4'b0010, 1'b1, 1); check_all();
    peek(0);
    chk(rd_raise_cyc == CW'(c1), "R1 held request stamp", rd_raise_cyc, c1);

    // R2: rise and take of the same line in one cycle
    step(4'b0011, 1'b1, 0); check_all();
    peek(0);
    chk(rd_latency == '0, "R2 same-cycle latency", rd_latency, 0);

    // R9: several lines rise together
    step(4'b0000, 1'b0, 0);
    step(4'b1111, 1'b0, 0); check_all();

    // R10: mid-run reset clears stamps; take without a new rise records 0
    do_reset();
    check_all();
    step(4'b0000, 1'b1, 2); check_all();
    peek(0);
    chk(rd_raise_cyc == '0, "R10 stamp cleared", rd_raise_cyc, 0);

    // R4: wrap after DEPTH takes; oldest index holds the second take
    do_reset();
    for (int i = 0; i <= D; i++) begin
      if (i == 1) tk2 = cyc;
      step(4'b0000, 1'b1, i % NL);
    end
    check_all();
    peek(D - 1);
    chk(rd_take_cyc == CW'(tk2), "R4 wrap overwrites oldest", rd_take_cyc, tk2);

    // sweep with pseudo-random stimulus, crossing the cycle counter wrap
    do_reset();
    cyc = CMASK - 40;
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], lf[4] & lf[7], int'(lf[6:5]));
      check_all();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule